// File: doc/BRIEF.md
# Clocked Serial Shifter with Self-Pausing Clock

This block moves 8-bit frames over a three-wire clocked serial link: a data output, a data input and a bidirectional serial clock. A host loads a byte into a transmit holding register and collects each received byte from a receive holding register. Three status flags report the state of those two registers: transmit empty, receive full and wait active. A fourth flag, overrun, reports lost receive data.

A 3-bit clock select input picks the clock source. Codes 0 to 6 make the block generate the serial clock from the system clock and drive it onto the clock pin. Code 7 makes it follow a clock supplied from outside, which it brings into the system clock domain through a two-stage synchronizer.

In generated-clock mode the block paces the link itself. A frame does not begin until the transmit register holds a byte and the receive register has been emptied. Between frames the clock rests high and the flag wait active is raised for the whole pause. In followed-clock mode the outside clock sets the pace. No pause is possible, and a frame that begins while unread data is still held raises overrun.

Top module: `ssio_top`

## Requirements
- R1: During and after synchronous reset, sck_out and so are 1, tx_empty is 1, and rx_full, wait_active and overrun are 0.
- R2: For clk_sel = n with n in 0..6, sck_oe is 1 and each low and each high phase of sck_out lasts 2^(n+1) system clock cycles.
- R3: In generated-clock mode, sck_out is 1 whenever no frame is in progress. A frame starts with a falling edge of sck_out on the cycle after tx_empty = 0 and rx_full = 0 are both seen.
- R4: Each frame carries 8 bits, least significant bit first. so takes a new bit with every falling clock edge, and si is sampled on every rising clock edge.
- R5: A write stores wr_data and clears tx_empty. Starting a frame moves the byte into the shifter and sets tx_empty. At the end of a frame the received byte appears on rd_data and rx_full is set. A read clears rx_full.
- R6: In generated-clock mode, once at least one frame has been sent, wait_active is 1 whenever no frame is in progress and either tx_empty or rx_full is 1. While wait_active is 1, sck_out stays at 1 and no bit is shifted.
- R7: clk_sel = 7 sets sck_oe to 0. The block then shifts on edges of sck_in after a two-flop synchronizer; each phase of sck_in must last more than 4 system clocks. A falling edge while idle starts a frame, and the 8th rising edge ends it.
- R8: With clk_sel = 7, wait_active stays 0. overrun is set when a frame starts while rx_full is 1 and no read happens in that cycle, and a read clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Clock source select; 0..6 selects a generated clock, 7 selects the external clock |
| wr_en | input | 1 | Write strobe for the transmit register |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe for the receive register |
| rd_data | output | 8 | Last received byte |
| tx_empty | output | 1 | Transmit register may be written |
| rx_full | output | 1 | Receive register holds unread data |
| wait_active | output | 1 | Generated clock is paused for service |
| overrun | output | 1 | A frame started while data was unread |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| sck_in | input | 1 | Clock pin input, used in external mode |
| sck_out | output | 1 | Clock pin output value |
| sck_oe | output | 1 | Clock pin output enable |

## Verification
If the phase counter or the bit counter is wrong, sck_out shows it within one half period: a phase of the wrong length, or a ninth clock pulse. A corrupted shift register shows on so at the next falling edge, and on rd_data when the frame ends. A bad flag shows directly on tx_empty, rx_full or wait_active in the cycle after the stimulus. In that case the clock is either never paused or stays paused, and sck_out stops toggling, or fails to stop, at once. All of this is caught by comparing every port against a reference on every cycle.

// File: rtl/ssio_pkg.sv
package ssio_pkg;
    localparam int DATA_W  = 8;
    localparam int SEL_W   = 3;
    localparam int CNT_W   = 8;
    localparam int BIT_W   = $clog2(DATA_W);
    localparam logic [SEL_W-1:0] SEL_EXT = '1;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic tx_empty;
        logic rx_full;
        logic overrun;
    } buf_stat_t;

    function automatic logic [CNT_W-1:0] half_cycles(input logic [SEL_W-1:0] sel);
        half_cycles = CNT_W'(1) << (sel + SEL_W'(1));
    endfunction
endpackage

// File: rtl/ssio_sync.sv
module ssio_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [2:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= 3'b111;
        else     stg <= {stg[1:0], pin};
    end

    always_comb begin
        rise = stg[1] & ~stg[2];
        fall = ~stg[1] & stg[2];
    end
endmodule

// File: rtl/ssio_bufs.sv
module ssio_bufs
    import ssio_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ext_mode,
    input  logic      wr_en,
    input  word_t     wr_data,
    input  logic      rd_en,
    input  logic      load,
    input  logic      done,
    input  word_t     done_word,
    output word_t     tx_word,
    output word_t     rx_word,
    output buf_stat_t stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_word <= '0;
            rx_word <= '0;
            stat    <= '{tx_empty: 1'b1, rx_full: 1'b0, overrun: 1'b0};
        end else begin
            if (wr_en) begin
                tx_word       <= wr_data;
                stat.tx_empty <= 1'b0;
            end else if (load) begin
                stat.tx_empty <= 1'b1;
            end
            if (done) begin
                rx_word      <= done_word;
                stat.rx_full <= 1'b1;
            end else if (rd_en) begin
                stat.rx_full <= 1'b0;
            end
            if (load && ext_mode && stat.rx_full && !rd_en) stat.overrun <= 1'b1;
            else if (rd_en)                                  stat.overrun <= 1'b0;
        end
    end

    // R5
    rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !done) |=> !stat.rx_full);
    // R5
    wr_clears_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !stat.tx_empty);
endmodule

// File: rtl/ssio_engine.sv
module ssio_engine
    import ssio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  word_t            tx_word,
    input  logic             tx_empty,
    input  logic             rx_full,
    input  logic             ext_rise,
    input  logic             ext_fall,
    input  logic             si,
    output logic             load,
    output logic             done,
    output word_t            done_word,
    output logic             sck_q,
    output logic             so_q,
    output logic             wait_active
);
    logic             busy, started, int_mode, phase_end, last, rise_ev, fall_ev;
    logic [CNT_W-1:0] phase_cnt, half;
    logic [BIT_W-1:0] bit_cnt;
    word_t            shreg;

    always_comb begin
        int_mode  = (sel != SEL_EXT);
        half      = half_cycles(sel);
        phase_end = (phase_cnt == half - CNT_W'(1));
        last      = (bit_cnt == BIT_W'(DATA_W - 1));
        load      = !busy && (int_mode ? (!tx_empty && !rx_full) : ext_fall);
        rise_ev   = busy && (int_mode ? (phase_end && !sck_q) : ext_rise);
        fall_ev   = busy && !last && (int_mode ? (phase_end && sck_q) : ext_fall);
        done      = int_mode ? (busy && phase_end && sck_q && last) : (rise_ev && last);
        done_word = int_mode ? shreg : {si, shreg[DATA_W-1:1]};
        wait_active = int_mode && started && !busy && (tx_empty || rx_full);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            started   <= 1'b0;
            phase_cnt <= '0;
            bit_cnt   <= '0;
            sck_q     <= 1'b1;
            so_q      <= 1'b1;
            shreg     <= '0;
        end else if (load) begin
            busy      <= 1'b1;
            started   <= started | int_mode;
            shreg     <= tx_word;
            so_q      <= tx_word[0];
            bit_cnt   <= '0;
            phase_cnt <= '0;
            sck_q     <= !int_mode;
        end else if (busy) begin
            phase_cnt <= phase_end ? '0 : phase_cnt + CNT_W'(1);
            if (rise_ev) begin
                shreg <= {si, shreg[DATA_W-1:1]};
                if (int_mode) sck_q <= 1'b1;
            end
            if (fall_ev) begin
                so_q    <= shreg[0];
                bit_cnt <= bit_cnt + BIT_W'(1);
                if (int_mode) sck_q <= 1'b0;
            end
            if (done) busy <= 1'b0;
        end
    end

    // R3
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (int_mode && !busy) |-> sck_q);
    // R4
    so_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (int_mode && !$stable(so_q)) |-> !sck_q);
    // R2
    phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (int_mode && busy) |-> (phase_cnt < half));
endmodule

// File: rtl/ssio_top.sv
module ssio_top
    import ssio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic             tx_empty,
    output logic             rx_full,
    output logic             wait_active,
    output logic             overrun,
    input  logic             si,
    output logic             so,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_oe
);
    logic      ext_rise, ext_fall, load, done, ext_mode;
    word_t     tx_word, done_word;
    buf_stat_t stat;

    assign ext_mode = (clk_sel == SEL_EXT);

    ssio_sync u_sync (
        .clk(clk), .rst(rst), .pin(sck_in), .rise(ext_rise), .fall(ext_fall)
    );

    ssio_engine u_engine (
        .clk(clk), .rst(rst), .sel(clk_sel), .tx_word(tx_word),
        .tx_empty(stat.tx_empty), .rx_full(stat.rx_full),
        .ext_rise(ext_rise), .ext_fall(ext_fall), .si(si),
        .load(load), .done(done), .done_word(done_word),
        .sck_q(sck_out), .so_q(so), .wait_active(wait_active)
    );

    ssio_bufs u_bufs (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .load(load), .done(done), .done_word(done_word),
        .tx_word(tx_word), .rx_word(rd_data), .stat(stat)
    );

    assign tx_empty = stat.tx_empty;
    assign rx_full  = stat.rx_full;
    assign overrun  = stat.overrun;
    assign sck_oe   = !ext_mode;

    // R6
    wait_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
        wait_active |-> sck_out);
    // R8
    ext_no_wait_chk: assert property (@(posedge clk) disable iff (rst)
        ext_mode |-> !wait_active);
endmodule

// File: tb/ssio_top_bench.sv
module ssio_top_bench;
    logic       clk = 0, rst = 1;
    logic [2:0] clk_sel = 0;
    logic       wr_en = 0, rd_en = 0, sck_in = 1, si_drv = 0, lb = 1;
    logic [7:0] wr_data = 0, rd_data;
    logic       tx_empty, rx_full, wait_active, overrun, so, sck_out, sck_oe, si;
    int tests = 0, fails = 0, cyc = 0;

    assign si = lb ? so : si_drv;
    always #10 clk = ~clk;

    ssio_top u_ssio_top (.*);

    // behavioural reference, updated at each rising edge
    int m_busy, m_start, m_ph, m_bit, m_sck, m_so, m_sh, m_tx, m_txe, m_rx, m_rxf, m_ovr;
    int m_s1, m_s2, m_s3;
    always @(posedge clk) begin
        int im, half, er, ef, ld, rs, fl, dn, sv;
        if (rst) begin
            m_busy = 0; m_start = 0; m_ph = 0; m_bit = 0; m_sck = 1; m_so = 1; m_sh = 0;
            m_tx = 0; m_txe = 1; m_rx = 0; m_rxf = 0; m_ovr = 0; m_s1 = 1; m_s2 = 1; m_s3 = 1;
        end else begin
            im = (clk_sel != 7); half = 1 << (clk_sel + 1);
            er = m_s2 && !m_s3; ef = !m_s2 && m_s3;
            ld = !m_busy && (im ? (!m_txe && !m_rxf) : ef);
            rs = m_busy && (im ? (m_ph == half-1 && !m_sck) : er);
            fl = m_busy && m_bit != 7 && (im ? (m_ph == half-1 && m_sck) : ef);
            dn = im ? (m_busy && m_ph == half-1 && m_sck && m_bit == 7) : (rs && m_bit == 7);
            sv = m_sh;
            if (ld && !im && m_rxf && !rd_en) m_ovr = 1; else if (rd_en) m_ovr = 0;
            if (dn) begin m_rx = im ? sv : ((sv >> 1) | (int'(si) << 7)); m_rxf = 1; end
            else if (rd_en) m_rxf = 0;
            if (ld) begin
                m_busy = 1; m_start = m_start | im; m_sh = m_tx; m_so = m_tx & 1;
                m_bit = 0; m_ph = 0; m_sck = im ? 0 : 1;
            end else if (m_busy) begin
                m_ph = (m_ph == half-1) ? 0 : m_ph + 1;
                if (rs) begin m_sh = (sv >> 1) | (int'(si) << 7); if (im) m_sck = 1; end
                if (fl) begin m_so = sv & 1; m_bit++; if (im) m_sck = 0; end
                if (dn) m_busy = 0;
            end
            if (wr_en) begin m_tx = wr_data; m_txe = 0; end else if (ld) m_txe = 1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = sck_in;
        end
    end

    always @(negedge clk) begin
        int mw;
        cyc++;
        if (!rst) begin
            mw = (clk_sel != 7) && m_start && !m_busy && (m_txe || m_rxf);
            tests++;
            if (sck_out !== m_sck[0] || so !== m_so[0] || tx_empty !== m_txe[0] ||
                rx_full !== m_rxf[0] || wait_active !== mw[0] || overrun !== m_ovr[0] ||
                rd_data !== m_rx[7:0] || sck_oe !== (clk_sel != 7)) begin
                fails++;
                $display("FAIL R2-R8 model cyc %0d: sck %b/%b so %b/%b txe %b/%b rxf %b/%b wait %b/%b ovr %b/%b rd %h/%h",
                    cyc, sck_out, m_sck[0], so, m_so[0], tx_empty, m_txe[0], rx_full, m_rxf[0],
                    wait_active, mw[0], overrun, m_ovr[0], rd_data, m_rx[7:0]);
            end
        end
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual hung, expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd();
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wait_rx();
        for (int i = 0; i < 5000 && !rx_full; i++) @(negedge clk);
    endtask

    task automatic ext_frame(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sck_in = 0; si_drv = b[i];
            repeat (5) @(negedge clk);
            sck_in = 1;
            repeat (5) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int lowc;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 sck", sck_out, 1); chk("R1 so", so, 1); chk("R1 txe", tx_empty, 1);
        chk("R1 rxf", rx_full, 0); chk("R1 wait", wait_active, 0); chk("R1 ovr", overrun, 0);
        rst = 0;
        @(negedge clk);
        chk("R3 idle high", sck_out, 1);
        // R4 R5 loopback frame, fastest clock
        wr(8'hA5);
        wait_rx();
        chk("R4 R5 rx byte", rd_data, 8'hA5);
        chk("R5 txe after load", tx_empty, 1);
        chk("R6 wait", wait_active, 1);
        for (int i = 0; i < 30; i++) begin @(negedge clk); chk("R6 held high", sck_out, 1); end
        rd();
        chk("R5 read clears", rx_full, 0);
        chk("R6 still waiting", wait_active, 1);
        // R2 phase length with code 2
        clk_sel = 2;
        wr(8'h3C);
        chk("R2 oe", sck_oe, 1);
        for (int i = 0; i < 20 && sck_out; i++) @(negedge clk);
        lowc = 0;
        while (!sck_out && lowc < 100) begin lowc++; @(negedge clk); end
        chk("R2 low phase", lowc, 8);
        wait_rx();
        chk("R4 rx 3C", rd_data, 8'h3C);
        rd();
        // R4 constant input
        clk_sel = 1; lb = 0; si_drv = 1;
        wr(8'h00);
        wait_rx();
        chk("R4 si ones", rd_data, 8'hFF);
        rd();
        // R7 external clock
        clk_sel = 7;
        wr(8'h96);
        @(negedge clk);
        chk("R7 oe", sck_oe, 0);
        chk("R8 no wait", wait_active, 0);
        ext_frame(8'h5A);
        chk("R7 ext rx", rd_data, 8'h5A);
        chk("R7 rxf", rx_full, 1);
        ext_frame(8'hC3);
        chk("R8 overrun", overrun, 1);
        chk("R8 no wait ext", wait_active, 0);
        chk("R7 second rx", rd_data, 8'hC3);
        rd();
        chk("R8 ovr cleared", overrun, 0);
        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule